// File: doc/BRIEF.md
# Auto-Reload Timer Square-Wave Clock Output

This block is a free-running auto-reload timer whose overflows drive an output pin as a square wave. A prescaler turns the system clock into a count enable on every second clock. The counter advances on each enable. When it passes its all-ones value, it takes the value held in a reload register in the same cycle. In clock-out mode each such overflow also flips the output pin. A half period therefore lasts 2×(2^W − reload) system clocks, and a full period lasts 4×(2^W − reload). With W = 16 the output frequency is Fclk / (4 × (65536 − reload)).

Software writes the reload value as two register bytes and controls the timer with three bits: run, external-count select and output enable. Clock-out mode requires the external-count select to be 0 and the output enable to be 1. An overflow in clock-out mode does not raise the timer interrupt pulse. Every overflow in timer mode produces a one-cycle rollover strobe. A baud-rate consumer can share this strobe, so its rate is tied to the same reload value.

Top module: `sqwave_timer_out`

## Requirements
- R1: After reset `clk_out` is 1, `rollover` and `tmr_irq` are 0, the counter is 0 and the reload value is 0.
- R2: In clock-out mode `clk_out` toggles every 2×(2^CNT_W − reload) clock cycles. The high and low halves are equal, which gives a 50% duty cycle.
- R3: `clk_out` changes only when clock-out mode is active: `ext_cnt_sel` = 0, `clk_out_en` = 1 and `run` = 1. In any other mode it holds its value.
- R4: While `run` = 0 the counter, the prescaler and `clk_out` hold their values. After `run` returns to 1 the interval in progress is stretched by exactly the number of cycles spent stopped.
- R5: An overflow in clock-out mode never raises `tmr_irq`. In timer mode with `clk_out_en` = 0, each overflow produces exactly one one-cycle `tmr_irq` pulse.
- R6: `rollover` pulses for exactly one cycle on every overflow while the timer counts, whatever the value of `clk_out_en`.
- R7: `rld_hi_we` writes `rld_wdata` into reload bits [CNT_W-1:CNT_W/2] and `rld_lo_we` writes it into bits [CNT_W/2-1:0]. A new reload value first takes effect at the next overflow, so the interval in progress keeps its length.
- R8: With `ext_cnt_sel` = 1 the counter does not count, and no `rollover` or `tmr_irq` pulse appears.
- R9: A reload of all ones gives the shortest period of 4 clocks. A reload of 0 gives the longest period of 4×2^CNT_W clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Starts (1) or freezes (0) the timer |
| ext_cnt_sel | input | 1 | 1 selects external-event counting, which does not count here; 0 selects timer mode |
| clk_out_en | input | 1 | Enables toggling of the output pin on overflow |
| rld_hi_we | input | 1 | Write strobe for the upper reload half |
| rld_lo_we | input | 1 | Write strobe for the lower reload half |
| rld_wdata | input | CNT_W/2 | Reload write data |
| clk_out | output | 1 | Square-wave clock output |
| rollover | output | 1 | One-cycle strobe on each overflow |
| tmr_irq | output | 1 | One-cycle interrupt pulse on an overflow outside clock-out mode |

## Verification
All three outputs are registered. `clk_out`, `rollover` and `tmr_irq` change one clock after the edge on which the counter overflows. The first `clk_out` edge after reset therefore falls 2×2^CNT_W clocks after reset is released. The bench samples at falling edges and measures the distance between successive `clk_out` changes in whole cycles, so the registered delay cancels and each half period is compared exactly with 2×(2^CNT_W − reload). A reload write is always made just after an edge, and the bench discards one interval before measuring, because the new value applies only from the next overflow. Pulse counts are taken over windows of exactly five intervals, which contain five overflows whatever their phase.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_TIMER  = 2'd1,
        MODE_CLKOUT = 2'd2
    } tmr_mode_e;
endpackage

// File: rtl/sqwave_prescale.sv
module sqwave_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = en_i && (st_q.cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/sqwave_reload.sv
module sqwave_reload #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hi_we_i,
    input  logic               lo_we_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic [CNT_W-1:0]   reload_o
);
    localparam int HW = CNT_W / 2;

    typedef struct packed {
        logic [HW-1:0] hi;
        logic [HW-1:0] lo;
    } rld_state_t;

    rld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_we_i) st_d.hi = wdata_i;
        if (lo_we_i) st_d.lo = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_o = {st_q.hi, st_q.lo};

    // R7
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we_i |=> reload_o[CNT_W-1:HW] == $past(wdata_i));
endmodule

// File: rtl/sqwave_counter.sv
module sqwave_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = tick_i && (&st_q.cnt);
        if (tick_i) begin
            st_d.cnt = ovf_o ? reload_i : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> st_q.cnt == $past(reload_i));
    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/sqwave_timer_out.sv
module sqwave_timer_out
    import sqwave_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ext_cnt_sel,
    input  logic               clk_out_en,
    input  logic               rld_hi_we,
    input  logic               rld_lo_we,
    input  logic [CNT_W/2-1:0] rld_wdata,
    output logic               clk_out,
    output logic               rollover,
    output logic               tmr_irq
);
    typedef struct packed {
        logic pin;
        logic roll;
        logic irq;
    } out_state_t;

    out_state_t st_d, st_q;
    tmr_mode_e  mode;
    logic       cnt_en;
    logic       tick;
    logic       ovf;
    logic [CNT_W-1:0] reload;

    always_comb begin
        if (!run || ext_cnt_sel) mode = MODE_IDLE;
        else if (clk_out_en)     mode = MODE_CLKOUT;
        else                     mode = MODE_TIMER;
    end

    assign cnt_en = (mode != MODE_IDLE);

    sqwave_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cnt_en),
        .tick_o (tick)
    );

    sqwave_reload #(.CNT_W(CNT_W)) u_rld (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we_i  (rld_hi_we),
        .lo_we_i  (rld_lo_we),
        .wdata_i  (rld_wdata),
        .reload_o (reload)
    );

    sqwave_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .en_i     (cnt_en),
        .reload_i (reload),
        .ovf_o    (ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.roll = ovf;
        st_d.irq  = ovf && (mode != MODE_CLKOUT);
        if (ovf && (mode == MODE_CLKOUT)) st_d.pin = !st_q.pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pin: 1'b1, roll: 1'b0, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign clk_out  = st_q.pin;
    assign rollover = st_q.roll;
    assign tmr_irq  = st_q.irq;

    // R3
    pin_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out != $past(clk_out)) |-> (rollover && $past(run && !ext_cnt_sel && clk_out_en)));
    // R5
    irq_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> (clk_out == $past(clk_out)));
    // R8
    ext_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ext_cnt_sel) |-> !rollover);
endmodule

// File: tb/sqwave_timer_out_tb.sv
module sqwave_timer_out_tb;
    localparam int W    = 8;
    localparam int HW   = W / 2;
    localparam int MAXV = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, ext_cnt_sel = 1'b0, clk_out_en = 1'b0;
    logic rld_hi_we = 1'b0, rld_lo_we = 1'b0;
    logic [HW-1:0] rld_wdata = '0;
    logic clk_out, rollover, tmr_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sqwave_timer_out #(.CNT_W(W), .PRE_DIV(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_cnt_sel(ext_cnt_sel),
        .clk_out_en(clk_out_en), .rld_hi_we(rld_hi_we), .rld_lo_we(rld_lo_we),
        .rld_wdata(rld_wdata), .clk_out(clk_out), .rollover(rollover), .tmr_irq(tmr_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedges until clk_out differs from its value at the call
    task automatic wait_toggle(output int n);
        logic prev;
        prev = clk_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (clk_out == prev && n < 4 * MAXV);
    endtask

    // takes exactly two negedges
    task automatic write_reload(input int r);
        rld_hi_we = 1'b1; rld_wdata = HW'(r >> HW);
        @(negedge clk);
        rld_hi_we = 1'b0; rld_lo_we = 1'b1; rld_wdata = HW'(r);
        @(negedge clk);
        rld_lo_we = 1'b0;
    endtask

    // counts rollover, irq pulses and clk_out changes over ncyc cycles
    task automatic count_window(input int ncyc, output int nr, output int ni, output int nt);
        logic prev;
        nr = 0; ni = 0; nt = 0;
        prev = clk_out;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (rollover) nr++;
            if (tmr_irq) ni++;
            if (clk_out != prev) nt++;
            prev = clk_out;
        end
    endtask

    task automatic measure_reload(input int r, input string req);
        int n, nh, nl;
        wait_toggle(n);
        write_reload(r);
        wait_toggle(n);
        wait_toggle(nh);
        wait_toggle(nl);
        check(req, nh, 2 * (MAXV - r));
        check({req, " duty"}, nl, nh);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, nr, ni, nt, half;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 clk_out", int'(clk_out), 1);
        check("R1 rollover", int'(rollover), 0);
        check("R1 tmr_irq", int'(tmr_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1; clk_out_en = 1'b1;
        // R1/R9: counter 0 and reload 0 give first edge at 2*2^W
        wait_toggle(n);
        check("R1 first interval", n, 2 * MAXV);
        wait_toggle(n);
        check("R9 reload 0 half", n, 2 * MAXV);

        // R2 sweep of the upper reload range
        for (int r = MAXV - 1; r >= MAXV - 96; r--) measure_reload(r, "R2");
        measure_reload(MAXV - 1, "R9 shortest");
        measure_reload(1, "R2 low reload");
        measure_reload(0, "R9 longest");

        // R7: new value applies only after the interval in progress
        measure_reload(200, "R7 setup");
        wait_toggle(n);
        write_reload(240);
        wait_toggle(n);
        check("R7 interval in progress", n + 2, 2 * (MAXV - 200));
        wait_toggle(n);
        check("R7 next interval", n, 2 * (MAXV - 240));
        // R7: lower half alone
        wait_toggle(n);
        rld_lo_we = 1'b1; rld_wdata = 4'h8;
        @(negedge clk);
        rld_lo_we = 1'b0;
        wait_toggle(n);
        wait_toggle(n);
        check("R7 low byte only", n, 2 * (MAXV - 8'hF8));

        // R4 pause stretches the interval by the stopped cycles
        half = 2 * (MAXV - 8'hF8);
        wait_toggle(n);
        repeat (3) @(negedge clk);
        run = 1'b0;
        count_window(37, nr, ni, nt);
        check("R4 clk_out held", nt, 0);
        check("R4 no rollover", nr, 0);
        run = 1'b1;
        wait_toggle(n);
        check("R4 stretched interval", n + 3 + 37, half + 37);

        // R5/R6/R3: timer mode without output
        wait_toggle(n);
        clk_out_en = 1'b0;
        count_window(5 * half, nr, ni, nt);
        check("R3 clk_out held", nt, 0);
        check("R6 rollover count", nr, 5);
        check("R5 irq count", ni, 5);

        // R8: external count select stops counting
        ext_cnt_sel = 1'b1;
        count_window(5 * half, nr, ni, nt);
        check("R8 rollover", nr, 0);
        check("R8 irq", ni, 0);
        check("R8 clk_out held", nt, 0);

        // R5/R6: clock-out mode again, no irq
        ext_cnt_sel = 1'b0; clk_out_en = 1'b1;
        count_window(5 * half, nr, ni, nt);
        check("R6 rollover clkout", nr, 5);
        check("R5 no irq in clkout", ni, 0);
        check("R2 toggles", nt, 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule